// File: doc/BRIEF.md
# Frame-Aligned Inversion Decoder and Lane Splitter

This block sits behind a clock-recovery stage on the receive side of a parallel link. It takes eleven serial data lanes, all sampled on one bit clock, and a separate frame line. Each lane carries 5-bit words. The frame line changes level exactly at the first bit of every word, so it toggles once every five bit times. The block uses those frame transitions to find word boundaries. It counts bit positions inside the word and reads the leading bit of each word as a polarity flag. It restores the 4-bit payload from that flag, then hands the payload out over two output cycles. Each lane drives one bit of a lower output bus and one bit of a higher output bus.

Lane k of the input drives bit k of the lower bus and bit k of the higher bus. Together these stand for output channel k and output channel k+11. If the frame line fails to move when the next word should begin, the block reports an alignment error. It then waits for the next transition before it decodes again.

Top module: `frame_inv_demux`

## Requirements
- R1: While reset is held and on the first cycle after it, `lo_data` and `hi_data` are all zero and `out_valid`, `out_second` and `align_err` are 0.
- R2: A frame transition is a cycle whose sampled `frame_in` differs from the value sampled one clock earlier. The lane bits sampled in that cycle are the word's polarity flags, and the lane bits of the next four cycles are payload bits 1, 2, 3 and 4 in that order.
- R3: On a lane whose flag is 1, the payload bits are passed to the outputs unchanged.
- R4: On a lane whose flag is 0, each payload bit is inverted before output.
- R5: On the clock after payload bit 4 is sampled, the block shows the first output cycle. In it `out_valid`=1 and `out_second`=0, `lo_data` carries restored bit 1 and `hi_data` carries restored bit 2. This gives a latency of one clock from the last bit of the word.
- R6: On the next clock, the second output cycle shows `out_valid`=1 and `out_second`=1, with restored bit 3 on `lo_data` and bit 4 on `hi_data`. On the clock after that, `out_valid` is 0 unless a new word has just completed.
- R7: A frame transition that arrives before a word is complete restarts the count at the flag position. The partial word produces no output and no error.
- R8: If a word has completed and the following sampled bit brings no frame transition, `align_err` is 1 for exactly one clock. No word is then decoded until the next transition.
- R9: The lanes are independent. Lane k's flag and payload affect only bit k of `lo_data` and `hi_data`.
- R10: The first frame sample after reset only sets the reference level. A constant frame line after reset yields no output and no alignment error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every lane and the frame line are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_in | input | 1 | Frame line; a level change marks the first bit of a word |
| lane_in | input | LANES | One serial bit per lane per clock |
| lo_data | output | LANES | Lower output channels (restored bits 1, then 3) |
| hi_data | output | LANES | Higher output channels (restored bits 2, then 4) |
| out_valid | output | 1 | High during the two output cycles of a decoded word |
| out_second | output | 1 | 0 in the first output cycle, 1 in the second |
| align_err | output | 1 | One-clock pulse when the frame line is quiet where a word should start |

## Verification
Several kinds of words are streamed back to back, each followed by the next word's frame toggle:
- Words with every flag 1 show that the payload passes straight through.
- Words with every flag 0 show the inversion.
- Words with mixed, walking and random flags separate per-lane handling from a shared polarity.

Idle stretches with a quiet frame line after a full word must raise one error. The same quiet line straight after reset must stay silent, which tells a primed reference apart from a reset-value edge. Short partial words cut off by an early toggle must vanish without output or error, which shows the restart rule.

// File: rtl/frame_inv_demux.sv
module frame_inv_demux #(
  parameter int LANES     = 11,
  parameter int WORD_BITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_in,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] lo_data,
  output logic [LANES-1:0] hi_data,
  output logic             out_valid,
  output logic             out_second,
  output logic             align_err
);
  localparam int CW = $clog2(WORD_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);
  localparam logic [CW-1:0] OVER = CW'(WORD_BITS);

  logic [CW-1:0]    pos;
  logic             primed, frame_q;
  logic [LANES-1:0] flag_r, p1_r, p2_r, p3_r, pend3, pend4;

  wire              tog       = primed && (frame_in != frame_q);
  wire              word_done = !tog && (pos == LAST);
  wire              lost      = !tog && (pos == OVER);
  wire [LANES-1:0]  inv       = ~flag_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      primed    <= 1'b0;
      frame_q   <= 1'b0;
      align_err <= 1'b0;
      flag_r    <= '0;
      p1_r      <= '0;
      p2_r      <= '0;
      p3_r      <= '0;
    end else begin
      primed    <= 1'b1;
      frame_q   <= frame_in;
      align_err <= lost;
      if (tog)               pos <= CW'(1);
      else if (lost)         pos <= '0;
      else if (pos != '0)    pos <= pos + CW'(1);
      if (tog)               flag_r <= lane_in;
      if (!tog && pos == CW'(1)) p1_r <= lane_in;
      if (!tog && pos == CW'(2)) p2_r <= lane_in;
      if (!tog && pos == CW'(3)) p3_r <= lane_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_data    <= '0;
      hi_data    <= '0;
      pend3      <= '0;
      pend4      <= '0;
      out_valid  <= 1'b0;
      out_second <= 1'b0;
    end else if (word_done) begin
      lo_data    <= p1_r ^ inv;
      hi_data    <= p2_r ^ inv;
      pend3      <= p3_r ^ inv;
      pend4      <= lane_in ^ inv;
      out_valid  <= 1'b1;
      out_second <= 1'b0;
    end else if (out_valid && !out_second) begin
      lo_data    <= pend3;
      hi_data    <= pend4;
      out_second <= 1'b1;
    end else begin
      out_valid  <= 1'b0;
      out_second <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_inv_demux_chk.sv
module frame_inv_demux_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_in,
  input logic out_valid,
  input logic out_second,
  input logic align_err
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> (!out_valid && !out_second && !align_err));

  assert_word_spans_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_second) |->
      ($past(frame_in, 5) != $past(frame_in, 6)) && ($past(frame_in, 1) == $past(frame_in, 5)));

  assert_first_then_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_second) |=> (out_valid && out_second));

  assert_no_third_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_second) |=> !(out_valid && out_second));

  assert_second_needs_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_second |-> out_valid);

  assert_err_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> !align_err);

  assert_err_on_quiet_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> ($past(frame_in, 1) == $past(frame_in, 2)));
endmodule

bind frame_inv_demux frame_inv_demux_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_in  (frame_in),
  .out_valid (out_valid),
  .out_second(out_second),
  .align_err (align_err)
);

// File: tb/frame_inv_demux_bench.sv
module frame_inv_demux_bench;
  localparam int L   = 11;
  localparam int CLK = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_in = 1'b1;
  logic [L-1:0] lane_in = '0;
  logic [L-1:0] lo_data, hi_data;
  logic         out_valid, out_second, align_err;

  frame_inv_demux #(.LANES(L)) u_frame_inv_demux (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .lane_in(lane_in),
    .lo_data(lo_data), .hi_data(hi_data), .out_valid(out_valid),
    .out_second(out_second), .align_err(align_err)
  );

  always #(CLK/2) clk = ~clk;

  int checks = 0, fails = 0;
  int err_exp = 0, err_seen = 0;
  logic frame_lvl = 1'b1;
  bit   aligned = 0;
  bit   running = 0;
  logic [2*L:0] exp_q[$];

  task automatic send_word(input logic [L-1:0] flag, input logic [4*L-1:0] nib);
    logic [L-1:0] inv;
    inv = ~flag;
    frame_lvl = ~frame_lvl;
    exp_q.push_back({1'b0, nib[L +: L], nib[0 +: L]});
    exp_q.push_back({1'b1, nib[3*L +: L], nib[2*L +: L]});
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      frame_in = frame_lvl;
      lane_in  = (i == 0) ? flag : (nib[(i-1)*L +: L] ^ inv);
    end
    aligned = 1;
  endtask

  task automatic send_partial(input int k);
    frame_lvl = ~frame_lvl;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      frame_in = frame_lvl;
      lane_in  = L'($urandom());
    end
    aligned = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_in = frame_lvl;
      lane_in  = L'($urandom());
    end
    if (aligned && n > 0) err_exp++;
    aligned = 0;
    @(negedge clk);
    #1;
    checks++;
    if (err_seen != err_exp) begin
      fails++;
      $display("FAIL %s: align_err count actual %0d expected %0d", tag, err_seen, err_exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (align_err) err_seen++;
      if (out_valid) begin
        logic [2*L:0] e;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R7 R10: unexpected output lo=%h hi=%h second=%0d expected none",
                   lo_data, hi_data, out_second);
        end else begin
          e = exp_q.pop_front();
          if ({out_second, hi_data, lo_data} != e) begin
            fails++;
            $display("FAIL R3 R4 R5 R6 R9: actual second=%0d hi=%h lo=%h expected second=%0d hi=%h lo=%h",
                     out_second, hi_data, lo_data, e[2*L], e[2*L-1:L], e[L-1:0]);
          end
        end
      end
    end
  end

  initial begin
    #(CLK * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [4*L-1:0] nib;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    checks++;
    if (lo_data !== '0 || hi_data !== '0 || out_valid !== 1'b0 || out_second !== 1'b0 || align_err !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual lo=%h hi=%h v=%b s=%b e=%b expected all zero",
               lo_data, hi_data, out_valid, out_second, align_err);
    end
    running = 1;
    // R10: constant frame line after reset is no edge
    idle(7, "R10");

    // R3: all flags 1
    send_word('1, {L'(11'h5A3), L'(11'h0F0), L'(11'h7FF), L'(11'h001)});
    // R4: all flags 0
    send_word('0, {L'(11'h123), L'(11'h456), L'(11'h000), L'(11'h3C5)});
    // R9: mixed and walking flags
    send_word(L'(11'h555), {L'(11'h2AA), L'(11'h555), L'(11'h7FF), L'(11'h000)});
    for (int j = 0; j < L; j++) send_word(L'(1) << j, {4{L'(1) << j}});
    for (int j = 0; j < 20; j++) begin
      nib = {L'($urandom()), L'($urandom()), L'($urandom()), L'($urandom())};
      send_word(L'($urandom()), nib);
    end
    // R8: quiet frame after a full word
    idle(3, "R8");
    send_word(L'(11'h0F3), {L'(11'h111), L'(11'h222), L'(11'h444), L'(11'h088)});
    idle(1, "R8");
    // R7: early toggles restart the word
    send_partial(3);
    send_word(L'(11'h7C0), {L'(11'h0AB), L'(11'h1CD), L'(11'h2EF), L'(11'h301)});
    send_partial(1);
    send_partial(4);
    send_word('1, {L'(11'h600), L'(11'h00C), L'(11'h030), L'(11'h180)});
    idle(2, "R7 R8");
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 R6: pending outputs actual %0d expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule